// File: doc/BRIEF.md
# Byte-Handshaked I2C Master Controller

This block is a register-driven I2C bus master that moves exactly one byte per software handshake. Software loads a byte into the data register. It then writes the status register with a master mode, the transfer-enable bit and the start flag. The controller puts a START condition on the bus and shifts the byte out, most significant bit first. It also clocks the acknowledge slot. When the ninth SCL pulse has finished, the controller raises a pending flag, holds SCL low and waits.

Software can answer the pending flag in three ways:
- Write the control register with the pending bit at 0 to move the next byte.
- Write the status register with the start flag set to issue a repeated START. This write can also switch between transmit and receive.
- Write the status register with the start flag clear to end the transfer with a STOP.

In receive mode the controller drives the acknowledge slot from an acknowledge-enable bit. Clearing that bit before the last byte makes the controller answer that byte with NACK.

SCL and SDA are open-drain. An `_oe` output at 1 pulls its line low, and the `_i` inputs return the wired level. A bus monitor on the returned lines tracks START and STOP and reports the bus as busy. The SCL rate comes from a tick counter. The counter divides the clock by a selectable prescale and a 4-bit divisor, and every SCL period is split into four equal phases.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset:
  - the control register (select 0) reads 0x00 and the status register (select 1) reads 0x00;
  - `scl_oe`, `sda_oe` and `irq` are 0.
- R2: START command. Writing select 1 with bit 7 = 1, bit 5 = 1 and bit 4 = 1 while the controller is idle does the following:
  - SDA falls while SCL is high;
  - status bit 5 (busy) then reads 1;
  - the byte held in the data register (select 2) is sent MSB first as the address byte.
- R3: Pending flag and interrupt.
  - After the acknowledge slot of each byte, control bit 4 reads 1.
  - SCL stays low for as long as that bit stays set.
  - `irq` equals that bit ANDed with control bit 5.
- R4: Status bit 0 reads 1 when the acknowledge slot of the last transmitted byte was high (NACK), and 0 when it was low.
- R5: In transmit mode, a control write with bit 4 = 0 while the pending bit is set clears the pending bit and sends the current data register byte.
- R6: Receive mode (status bits 7:6 = 10).
  - After the address byte, each pending clear receives one byte into the data register.
  - The controller drives the acknowledge slot low when control bit 7 = 1, and leaves it high when control bit 7 = 0.
- R7: A START command written while the pending bit is set produces a repeated START with no STOP before it. It applies the newly written mode to the bytes that follow the address.
- R8: STOP command.
  - A status write with bit 7 = 1, bit 5 = 0 and bit 4 = 1 while the pending bit is set produces a STOP (SDA rises while SCL is high).
  - Busy then reads 0.
- R9: SCL timing. The time from one SCL rising edge to the next inside a byte is P × (D + 1) clocks.
  - D is control bits 3:0.
  - P is 16 when control bit 6 = 0 and 512 when control bit 6 = 1.
- R10: SDA changes only while SCL is low, except at START and STOP. A transfer therefore contains exactly one START per START command and one STOP per STOP command.
- R11: Writes that arrive while the controller is shifting have no effect:
  - data register writes outside the idle or pending state do not change the byte sent;
  - a control write with bit 4 = 1 neither starts a byte nor sets the pending bit.
- R12: The own-address register (select 3) keeps and returns the last value written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_sel | input | 2 | Register select: 0 control, 1 status, 2 data, 3 own address |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| irq | output | 1 | Interrupt: pending flag gated by the interrupt enable |
| scl_i | input | 1 | Wired SCL level |
| sda_i | input | 1 | Wired SDA level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The hardest case to reach from the ports is a combined read:
- an address in write mode, then a register index;
- a repeated START that turns the controller into a receiver;
- acknowledged bytes, then a final byte answered with NACK because the acknowledge enable was cleared in the same write that releases the byte.

The bench gets there with a bit-level slave model built on the wired lines. The slave decodes START and STOP and acknowledges only its own address. It returns a fixed byte pattern on reads and records the acknowledge level the master gives each byte. The bench then compares the received bytes and those recorded acknowledge levels with the expected sequence.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;
  typedef enum logic [2:0] {
    EN_IDLE,
    EN_START,
    EN_BIT,
    EN_HOLD,
    EN_STOP
  } eng_st_t;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam logic [1:0] SEL_OWN  = 2'd3;
endpackage

// File: rtl/i2c_bm_clkdiv.sv
module i2c_bm_clkdiv #(
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 512,
  parameter int DIVW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            pre_hi,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  localparam int Q_LO = PRE_LO / 4;
  localparam int Q_HI = PRE_HI / 4;
  localparam int CW   = $clog2(Q_HI * (2 ** DIVW)) + 1;

  logic [CW-1:0] cnt_q, cnt_d, limit;

  // one phase lasts quarter-prescale times (divisor + 1) clocks
  always_comb begin
    limit = CW'(pre_hi ? Q_HI : Q_LO) * (CW'(div) + CW'(1)) - CW'(1);
    tick  = run && (cnt_q == limit);
    cnt_d = (!run || tick) ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2c_bm_busmon.sv
module i2c_bm_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_sync,
  output logic busy
);
  logic [1:0] scl_s, sda_s;
  logic       scl_p, sda_p, busy_q, busy_d;
  logic       start_det, stop_det;

  always_comb begin
    start_det = scl_s[1] && scl_p && sda_p && !sda_s[1];
    stop_det  = scl_s[1] && scl_p && !sda_p && sda_s[1];
    busy_d    = busy_q;
    if (start_det)     busy_d = 1'b1;
    else if (stop_det) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s  <= 2'b11;
      sda_s  <= 2'b11;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      scl_s  <= {scl_s[0], scl_i};
      sda_s  <= {sda_s[0], sda_i};
      scl_p  <= scl_s[1];
      sda_p  <= sda_s[1];
      busy_q <= busy_d;
    end
  end

  assign sda_sync = sda_s[1];
  assign busy     = busy_q;
endmodule

// File: rtl/i2c_bm_engine.sv
module i2c_bm_engine
  import i2c_bm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       sda_in,
  input  logic       cmd_start,
  input  logic       cmd_stop,
  input  logic       cmd_go,
  input  logic       rx_sel,
  input  logic       ack_en,
  input  logic       data_we,
  input  logic [7:0] data_wd,
  output logic [7:0] shreg,
  output logic       pend,
  output logic       nack,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       run,
  output logic       in_ss
);
  eng_st_t    st_q, st_d;
  logic [1:0] ph_q, ph_d;
  logic [3:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic       pend_q, pend_d, nack_q, nack_d, rs_q, rs_d;
  logic       rxm_q, rxm_d, rx_q, rx_d, smp_q, smp_d, ack_q, ack_d;

  always_comb begin
    st_d = st_q; ph_d = ph_q; bit_d = bit_q; sh_d = sh_q;
    pend_d = pend_q; nack_d = nack_q; rs_d = rs_q; rxm_d = rxm_q;
    rx_d = rx_q; smp_d = smp_q; ack_d = ack_q;
    if (data_we && (st_q == EN_IDLE || st_q == EN_HOLD)) sh_d = data_wd;
    case (st_q)
      EN_IDLE: if (cmd_start) begin
        st_d = EN_START; ph_d = 2'd0; rs_d = 1'b0; rxm_d = rx_sel; rx_d = 1'b0;
      end
      EN_HOLD: begin
        if (cmd_start) begin
          st_d = EN_START; ph_d = 2'd0; rs_d = 1'b1; rxm_d = rx_sel;
          rx_d = 1'b0; pend_d = 1'b0;
        end else if (cmd_stop) begin
          st_d = EN_STOP; ph_d = 2'd0; pend_d = 1'b0;
        end else if (cmd_go) begin
          st_d = EN_BIT; ph_d = 2'd0; bit_d = 4'd0; rx_d = rxm_q;
          ack_d = ack_en; pend_d = 1'b0;
        end
      end
      EN_START: if (tick) begin
        ph_d = ph_q + 2'd1;
        if (ph_q == 2'd3) begin st_d = EN_BIT; bit_d = 4'd0; end
      end
      EN_BIT: if (tick) begin
        ph_d = ph_q + 2'd1;
        if (ph_q == 2'd2) begin
          smp_d = sda_in;
          if (bit_q == 4'd8 && !rx_q) nack_d = sda_in;
        end
        if (ph_q == 2'd3) begin
          if (bit_q == 4'd8) begin
            st_d = EN_HOLD; pend_d = 1'b1;
          end else begin
            sh_d = {sh_q[6:0], smp_q}; bit_d = bit_q + 4'd1;
          end
        end
      end
      EN_STOP: if (tick) begin
        ph_d = ph_q + 2'd1;
        if (ph_q == 2'd3) st_d = EN_IDLE;
      end
      default: st_d = EN_IDLE;
    endcase
  end

  // line drivers: four phases per bit, SCL high in phases 1 and 2
  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st_q)
      EN_START: begin
        scl_oe = (ph_q == 2'd0 && rs_q) || ph_q == 2'd3;
        sda_oe = ph_q >= 2'd2;
      end
      EN_BIT: begin
        scl_oe = ph_q == 2'd0 || ph_q == 2'd3;
        sda_oe = (bit_q < 4'd8) ? (!rx_q && !sh_q[7]) : (rx_q && ack_q);
      end
      EN_HOLD: scl_oe = 1'b1;
      EN_STOP: begin
        scl_oe = ph_q == 2'd0;
        sda_oe = ph_q != 2'd3;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= EN_IDLE; ph_q <= 2'd0; bit_q <= 4'd0; sh_q <= 8'd0;
      pend_q <= 1'b0; nack_q <= 1'b0; rs_q <= 1'b0; rxm_q <= 1'b0;
      rx_q <= 1'b0; smp_q <= 1'b0; ack_q <= 1'b0;
    end else begin
      st_q <= st_d; ph_q <= ph_d; bit_q <= bit_d; sh_q <= sh_d;
      pend_q <= pend_d; nack_q <= nack_d; rs_q <= rs_d; rxm_q <= rxm_d;
      rx_q <= rx_d; smp_q <= smp_d; ack_q <= ack_d;
    end
  end

  assign shreg = sh_q;
  assign pend  = pend_q;
  assign nack  = nack_q;
  assign run   = (st_q == EN_START) || (st_q == EN_BIT) || (st_q == EN_STOP);
  assign in_ss = (st_q == EN_START) || (st_q == EN_STOP);
endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_bm_pkg::*;
#(
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 512,
  parameter int DIVW   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_sel,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe
);
  logic [1:0]      rsync_q;
  logic            rst_sync_n;
  logic            ack_en_q, pre_q, ien_q, txen_q;
  logic [DIVW-1:0] div_q;
  logic [1:0]      mode_q;
  logic [7:0]      own_q;
  logic            ctrl_we, stat_we, data_we, own_we;
  logic            cmd_start, cmd_stop, cmd_go, ack_live;
  logic            tick, run, in_ss, busy, sda_sync, pend, nack;
  logic [7:0]      shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  always_comb begin
    ctrl_we   = reg_wr && reg_sel == SEL_CTRL;
    stat_we   = reg_wr && reg_sel == SEL_STAT;
    data_we   = reg_wr && reg_sel == SEL_DATA;
    own_we    = reg_wr && reg_sel == SEL_OWN;
    cmd_start = stat_we && reg_wdata[7] && reg_wdata[4] && reg_wdata[5];
    cmd_stop  = stat_we && reg_wdata[7] && reg_wdata[4] && !reg_wdata[5];
    cmd_go    = ctrl_we && !reg_wdata[4];
    ack_live  = ctrl_we ? reg_wdata[7] : ack_en_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ack_en_q <= 1'b0; pre_q <= 1'b0; ien_q <= 1'b0; div_q <= '0;
      mode_q <= 2'b00; txen_q <= 1'b0; own_q <= 8'd0;
    end else begin
      if (ctrl_we) begin
        ack_en_q <= reg_wdata[7]; pre_q <= reg_wdata[6];
        ien_q <= reg_wdata[5]; div_q <= reg_wdata[DIVW-1:0];
      end
      if (stat_we) begin
        mode_q <= reg_wdata[7:6]; txen_q <= reg_wdata[4];
      end
      if (own_we) own_q <= reg_wdata;
    end
  end

  i2c_bm_clkdiv #(.PRE_LO(PRE_LO), .PRE_HI(PRE_HI), .DIVW(DIVW)) u_div (
    .clk(clk), .rst_n(rst_sync_n), .run(run), .pre_hi(pre_q), .div(div_q), .tick(tick)
  );

  i2c_bm_busmon u_mon (
    .clk(clk), .rst_n(rst_sync_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_sync(sda_sync), .busy(busy)
  );

  i2c_bm_engine u_eng (
    .clk(clk), .rst_n(rst_sync_n), .tick(tick), .sda_in(sda_sync),
    .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_go(cmd_go),
    .rx_sel(!reg_wdata[6]), .ack_en(ack_live), .data_we(data_we),
    .data_wd(reg_wdata), .shreg(shreg), .pend(pend), .nack(nack),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .run(run), .in_ss(in_ss)
  );

  always_comb begin
    case (reg_sel)
      SEL_CTRL: reg_rdata = {ack_en_q, pre_q, ien_q, pend, 4'(div_q)};
      SEL_STAT: reg_rdata = {mode_q, busy, txen_q, 3'b000, nack};
      SEL_DATA: reg_rdata = shreg;
      default:  reg_rdata = own_q;
    endcase
  end

  assign irq = pend && ien_q;
endmodule

// File: rtl/i2c_byte_master_chk.sv
module i2c_byte_master_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_oe,
  input logic sda_oe,
  input logic busy,
  input logic pend,
  input logic run,
  input logic in_ss
);
  // R1: idle controller leaves both lines released
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !pend) |-> (!scl_oe && !sda_oe));

  // R3: SCL is held low while a byte waits for software
  a_r3_hold_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> scl_oe);

  // R10: SDA moves under a released SCL only in START or STOP
  a_r10_sda_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe))) |-> in_ss);

  // R2: a detected START finds SCL released
  a_r2_start_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !scl_oe);

  // R8: a detected STOP finds SDA released
  a_r8_stop_sda_released: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !sda_oe);
endmodule

bind i2c_byte_master i2c_byte_master_chk chk_i (
  .clk(clk), .rst_n(rst_sync_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .busy(busy), .pend(pend), .run(run), .in_ss(in_ss)
);

// File: tb/i2c_byte_master_tb_top.sv
module i2c_byte_master_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] sel = 2'd0;
  logic       wr = 1'b0;
  logic [7:0] wd = 8'd0;
  logic [7:0] rd;
  logic       irq, scl_oe, sda_oe, scl_i, sda_i;
  int         nchk = 0, nfail = 0, cyc = 0;
  bit         done = 1'b0;

  // bench-side slave (address 0x50)
  logic       sl_low = 1'b0, sl_act = 1'b0, sl_first = 1'b0, sl_skip = 1'b0;
  logic       sl_rd = 1'b0, sl_sel = 1'b0, sl_mok = 1'b0;
  logic [7:0] sl_sh = 8'd0, sl_tx = 8'd0;
  int         sl_bn = 0, starts = 0, stops = 0, wn = 0, ti = 0, mn = 0;
  logic [7:0] wlog [0:15];
  logic       mack [0:7];

  assign scl_i = !scl_oe;
  assign sda_i = !(sda_oe || sl_low);

  always #10 clk = !clk;
  always @(posedge clk) cyc++;

  i2c_byte_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(sel), .reg_wr(wr), .reg_wdata(wd),
    .reg_rdata(rd), .irq(irq), .scl_i(scl_i), .sda_i(sda_i),
    .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  function automatic logic [7:0] tx_pat(int i);
    return (i == 0) ? 8'hA5 : (i == 1) ? 8'h3C : 8'h81;
  endfunction

  always @(negedge sda_i) if (scl_i === 1'b1) begin
    starts++; sl_act = 1'b1; sl_first = 1'b1; sl_skip = 1'b1; sl_bn = 0; sl_low = 1'b0;
  end
  always @(posedge sda_i) if (scl_i === 1'b1) begin
    stops++; sl_act = 1'b0; sl_low = 1'b0;
  end
  always @(posedge scl_i) if (sl_act) begin
    if (sl_bn < 8) sl_sh = {sl_sh[6:0], sda_i};
    else if (sl_rd && !sl_first) begin
      sl_mok = !sda_i;
      if (mn < 8) mack[mn] = !sda_i;
      mn++;
    end
  end
  always @(negedge scl_i) if (sl_act) begin
    if (sl_skip) sl_skip = 1'b0;
    else if (sl_bn == 7) begin
      sl_bn = 8;
      if (sl_first) begin
        sl_sel = (sl_sh[7:1] == 7'h50); sl_rd = sl_sh[0]; sl_low = sl_sel;
        if (wn < 16) wlog[wn] = sl_sh;
        wn++;
      end else if (!sl_rd) begin
        if (wn < 16) wlog[wn] = sl_sh;
        wn++; sl_low = 1'b1;
      end else sl_low = 1'b0;
    end else if (sl_bn == 8) begin
      sl_bn = 0;
      if (sl_rd && sl_sel && (sl_first || sl_mok)) begin
        sl_tx = tx_pat(ti); ti++; sl_low = !sl_tx[7];
      end else sl_low = 1'b0;
      if (sl_first && !sl_sel) sl_act = 1'b0;
      sl_first = 1'b0;
    end else begin
      sl_bn++;
      if (sl_rd && !sl_first) sl_low = !sl_tx[7-sl_bn];
    end
  end

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(logic [1:0] s, logic [7:0] v);
    @(negedge clk); sel = s; wd = v; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(logic [1:0] s, output logic [7:0] v);
    @(negedge clk); sel = s; #1; v = rd;
  endtask

  task automatic wait_pend();
    logic [7:0] v;
    for (int i = 0; i < 30000; i++) begin
      rd_reg(2'd0, v);
      if (v[4]) return;
    end
    chk("R3 pending timeout", 0, 1);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd_reg(2'd0, v); chk("R1 control", v, 8'h00);
    rd_reg(2'd1, v); chk("R1 status", v, 8'h00);
    chk("R1 scl_oe", scl_oe, 0);
    chk("R1 sda_oe", sda_oe, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_own();
    logic [7:0] v;
    wr_reg(2'd3, 8'h5A); rd_reg(2'd3, v); chk("R12 own address", v, 8'h5A);
  endtask

  task automatic t_write();
    logic [7:0] v;
    int w0 = wn, s0 = starts, p0 = stops;
    wr_reg(2'd0, 8'hA0);
    wr_reg(2'd2, 8'hA0);
    wr_reg(2'd1, 8'hF0);
    idle(10);
    rd_reg(2'd1, v); chk("R2 busy after START", v[5], 1);
    wr_reg(2'd2, 8'hFF);              // R11: ignored, shifting
    wr_reg(2'd0, 8'hB0);              // R11: bit4=1 does nothing
    rd_reg(2'd0, v); chk("R11 pending not set by write", v[4], 0);
    wait_pend();
    chk("R2 R11 address byte on bus", wlog[w0], 8'hA0);
    chk("R3 irq with enable", irq, 1);
    idle(40);
    chk("R3 SCL held low", scl_i, 0);
    rd_reg(2'd0, v); chk("R3 pending stays", v[4], 1);
    rd_reg(2'd1, v); chk("R4 ack seen", v[0], 0);
    wr_reg(2'd2, 8'h12); wr_reg(2'd0, 8'hA0); wait_pend();
    wr_reg(2'd2, 8'h34); wr_reg(2'd0, 8'hA0); wait_pend();
    chk("R5 first data byte", wlog[w0+1], 8'h12);
    chk("R5 second data byte", wlog[w0+2], 8'h34);
    wr_reg(2'd1, 8'hD0);
    idle(40);
    rd_reg(2'd1, v); chk("R8 busy clears", v[5], 0);
    chk("R8 one STOP", stops, p0 + 1);
    chk("R10 one START", starts, s0 + 1);
  endtask

  task automatic t_nack();
    logic [7:0] v;
    int p0 = stops;
    wr_reg(2'd0, 8'h80);
    wr_reg(2'd2, 8'hB0);
    wr_reg(2'd1, 8'hF0);
    wait_pend();
    chk("R3 irq masked", irq, 0);
    rd_reg(2'd1, v); chk("R4 nack flag", v[0], 1);
    wr_reg(2'd1, 8'hD0);
    idle(40);
    chk("R8 STOP after nack", stops, p0 + 1);
  endtask

  task automatic t_read();
    logic [7:0] v;
    int w0 = wn, m0 = mn, s0, p0;
    wr_reg(2'd0, 8'hA0);
    wr_reg(2'd2, 8'hA0); wr_reg(2'd1, 8'hF0); wait_pend();
    wr_reg(2'd2, 8'h07); wr_reg(2'd0, 8'hA0); wait_pend();
    chk("R5 index byte", wlog[w0+1], 8'h07);
    s0 = starts; p0 = stops;
    wr_reg(2'd2, 8'hA1); wr_reg(2'd1, 8'hB0); wait_pend();
    chk("R7 repeated START", starts, s0 + 1);
    chk("R7 no STOP before it", stops, p0);
    rd_reg(2'd1, v);
    chk("R7 read address acked", v[0], 0);
    chk("R7 mode receive", v[7:6], 2'b10);
    wr_reg(2'd0, 8'hA0); wait_pend();
    rd_reg(2'd2, v); chk("R6 first received byte", v, 8'hA5);
    chk("R6 master ack", mack[m0], 1);
    wr_reg(2'd0, 8'h20); wait_pend();
    rd_reg(2'd2, v); chk("R6 last received byte", v, 8'h3C);
    chk("R6 master nack on last", mack[m0+1], 0);
    wr_reg(2'd1, 8'h90);
    idle(40);
    rd_reg(2'd1, v); chk("R8 busy clears after read", v[5], 0);
  endtask

  task automatic t_timing(logic [3:0] dv, logic ps, int exp);
    int t0, t1;
    wr_reg(2'd0, {1'b1, ps, 2'b10, dv});
    wr_reg(2'd2, 8'hA0);
    wr_reg(2'd1, 8'hF0);
    @(posedge scl_i); t0 = cyc;
    @(posedge scl_i); t1 = cyc;
    chk("R9 SCL period", t1 - t0, exp);
    wait_pend();
    wr_reg(2'd1, 8'hD0);
    idle(exp + 100);
  endtask

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_own();
    t_write();
    t_nack();
    t_read();
    t_timing(4'd1, 1'b0, 32);
    t_timing(4'd0, 1'b1, 512);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule